// File: doc/BRIEF.md
# Dual-Phase Frame Serial Transmitter

This block turns a stream of parallel words into a single serial data line, organised in frames. A frame is made of one or two phases. Each phase has its own word count and word length, so a frame can, for example, carry one 16-bit word followed by twelve 20-bit words. The block makes its own bit clock from the system clock. Serial data and an active-high frame-sync pulse change together with each rising edge of that bit clock.

Words arrive over a valid/ready input and wait in a single holding register until their slot begins. The gap between the sync pulse and the first data bit of a frame can be 0, 1 or 2 bit periods. Once the first frame has started, frames follow one another with no idle bits between them. The sync pulse for a frame therefore falls inside the tail of the frame before it. If a slot begins while no word is waiting, the slot carries zeros and a one-cycle underrun pulse is raised.

Configuration is sampled at each sync bit and governs the frame that the sync announces. The first frame takes its configuration at the first bit after reset.

Top module: `dpf_tx`

## Requirements
- R1: `bclk_o` stays high for HALF_CYC system cycles and then low for HALF_CYC cycles, and starts low after reset. `sdata_o` and `fsync_o` change only on the system edge at which `bclk_o` rises.
- R2: While reset is held, `bclk_o`, `fsync_o`, `sdata_o` and `underrun_o` are 0 and `in_ready` is 1.
- R3: `fsync_o` is high for exactly one bit period per frame. The first bit after reset is a sync bit. The delay code sets the distance from the sync bit to the first data bit of its frame: 00 gives 0 bits (same bit), 01 gives 1 bit and 10 gives 2 bits. Before the first frame the line carries 0 during the delay bits.
- R4: Word-length codes are 000 for 8 bits, 001 for 12, 010 for 16, 011 for 20, 100 for 24 and 101 for 32. Each word is sent most significant bit first. Only the low word-length bits of `in_data` are sent.
- R5: A frame-length field holds the word count minus one. With `cfg_dual` = 0 a frame holds only phase 1, and the phase-2 fields have no effect on the line. With `cfg_dual` = 1, phase 2 follows phase 1.
- R6: The first bit of a frame directly follows the last bit of the previous frame. With delay D, the sync for the next frame is sent D bits before that frame's first bit, which places it inside the previous frame when D > 0.
- R7: A slot that begins while the holding register is empty sends all zeros. It also raises `underrun_o` for exactly one system cycle, on the edge at which the slot's first bit appears.
- R8: `in_ready` is high only while the holding register is empty. An accepted word drops `in_ready` on the next cycle. Words are sent in the order they were accepted.
- R9: The configuration inputs are sampled at each sync bit and apply to the frame that sync announces. Changes at any other time do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dual | input | 1 | 1 selects two-phase frames, 0 selects one phase |
| cfg_len1 | input | 7 | Phase-1 word count minus one |
| cfg_wlen1 | input | 3 | Phase-1 word-length code |
| cfg_len2 | input | 7 | Phase-2 word count minus one |
| cfg_wlen2 | input | 3 | Phase-2 word-length code |
| cfg_delay | input | 2 | Sync-to-data delay code |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Input word, right-aligned |
| in_ready | output | 1 | Holding register can take a word |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame-sync pulse, active high |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse when a slot starts with no word |

## Verification
With a non-zero delay, the sync bit for the next frame falls on a bit that still carries data of the current frame. When the delay is zero, the sync bit coincides with a slot load, and the configuration is sampled on that same edge. The bench runs back-to-back frames with delays of 0, 1 and 2. It compares the expected sync and data pair on every bit, so a sync placed or sampled on the wrong bit shows up as a mismatch. A further run changes the configuration in the middle of a frame and then withholds words for a whole frame. This checks that a configuration swap at the sync bit and an underrun at a slot start, both of which can occur on a sync bit, are each handled correctly.

// File: rtl/dpf_pkg.sv
`timescale 1ns/1ps
package dpf_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 7;
    localparam int WLC_W  = 3;
    localparam int DLY_W  = 2;
    localparam int WB_W   = $clog2(WORD_W) + 1;
    localparam int CNT_W  = LEN_W + 1 + WB_W + 1;

    typedef struct packed {
        logic             dual;
        logic [LEN_W-1:0] len1;
        logic [WLC_W-1:0] wc1;
        logic [LEN_W-1:0] len2;
        logic [WLC_W-1:0] wc2;
        logic [DLY_W-1:0] dly;
    } frame_cfg_t;

    typedef struct packed {
        logic              started;
        logic [DLY_W-1:0]  lead;
        logic [CNT_W-1:0]  left;
        logic [WB_W-1:0]   wbits;
        logic [WORD_W-1:0] sh;
        logic              ph;
        logic [LEN_W-1:0]  wd;
        frame_cfg_t        cur;
        frame_cfg_t        pend;
        logic              sd;
        logic              fs;
        logic              ur;
    } seq_st_t;

    function automatic logic [WB_W-1:0] word_bits(logic [WLC_W-1:0] code);
        case (code)
            3'b000:  return WB_W'(8);
            3'b001:  return WB_W'(12);
            3'b010:  return WB_W'(16);
            3'b011:  return WB_W'(20);
            3'b100:  return WB_W'(24);
            default: return WB_W'(32);
        endcase
    endfunction

    function automatic logic [DLY_W-1:0] dly_bits(logic [DLY_W-1:0] code);
        return (code == 2'b00) ? 2'd0 : (code == 2'b01) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [CNT_W-1:0] frame_bits(frame_cfg_t c);
        logic [CNT_W-1:0] p1;
        logic [CNT_W-1:0] p2;
        p1 = (CNT_W'(c.len1) + CNT_W'(1)) * CNT_W'(word_bits(c.wc1));
        p2 = (CNT_W'(c.len2) + CNT_W'(1)) * CNT_W'(word_bits(c.wc2));
        return c.dual ? (p1 + p2) : p1;
    endfunction

endpackage

// File: rtl/dpf_bitclk.sv
`timescale 1ns/1ps
module dpf_bitclk #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    output logic bclk,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } bc_st_t;

    bc_st_t q, n;

    always_comb begin
        n = q;
        if (q.cnt == LAST) begin
            n.cnt  = '0;
            n.bclk = !q.bclk;
        end else begin
            n.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign bclk = q.bclk;
    assign tick = (q.cnt == LAST) && !q.bclk;
endmodule

// File: rtl/dpf_hold.sv
`timescale 1ns/1ps
module dpf_hold
    import dpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              have,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] data;
    } hold_st_t;

    hold_st_t q, n;

    always_comb begin
        n = q;
        if (take) n.full = 1'b0;
        if (in_valid && !q.full) begin
            n.full = 1'b1;
            n.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign in_ready = !q.full;
    assign have     = q.full;
    assign word     = q.data;
endmodule

// File: rtl/dpf_seq.sv
`timescale 1ns/1ps
module dpf_seq
    import dpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_cfg_t        cfg_in,
    input  logic              have,
    input  logic [WORD_W-1:0] word,
    output logic              take,
    output logic              sdata,
    output logic              fsync,
    output logic              underrun
);
    seq_st_t q, n;

    frame_cfg_t        fcfg;
    logic              sync;
    logic              start;
    logic [DLY_W-1:0]  d_cur;
    logic [DLY_W-1:0]  d_in;
    logic [WB_W-1:0]   wl;
    logic [WORD_W-1:0] load;
    logic [WORD_W-1:0] aligned;
    logic              last;

    always_comb begin
        n       = q;
        n.ur    = 1'b0;
        take    = 1'b0;
        fcfg    = q.pend;
        sync    = 1'b0;
        start   = 1'b0;
        d_cur   = dly_bits(q.cur.dly);
        d_in    = dly_bits(cfg_in.dly);
        wl      = '0;
        load    = '0;
        aligned = '0;
        last    = 1'b0;
        if (tick) begin
            sync = !q.started || (q.lead == '0 && q.left == CNT_W'(d_cur));
            if (sync) begin
                n.pend = cfg_in;
                fcfg   = cfg_in;
            end
            if (!q.started) begin
                n.started = 1'b1;
                n.cur     = cfg_in;
                start     = (d_in == '0);
                n.lead    = (d_in == '0) ? '0 : DLY_W'(d_in - 2'd1);
            end else begin
                start = (q.left == '0) && (q.lead == '0);
            end
            n.fs = sync;
            n.sd = 1'b0;
            if (start) begin
                n.cur   = fcfg;
                n.left  = frame_bits(fcfg);
                n.ph    = 1'b0;
                n.wd    = '0;
                n.wbits = '0;
            end
            if (n.left != '0) begin
                wl = n.ph ? word_bits(n.cur.wc2) : word_bits(n.cur.wc1);
                if (n.wbits == '0) begin
                    if (have) begin
                        load = word;
                        take = 1'b1;
                    end else begin
                        n.ur = 1'b1;
                    end
                    aligned = load << (WB_W'(WORD_W) - wl);
                    n.sd    = aligned[WORD_W-1];
                    n.sh    = aligned << 1;
                    n.wbits = wl - WB_W'(1);
                    last    = (n.wd == (n.ph ? n.cur.len2 : n.cur.len1));
                    if (last) begin
                        n.wd = '0;
                        n.ph = !n.ph && n.cur.dual;
                    end else begin
                        n.wd = n.wd + LEN_W'(1);
                    end
                end else begin
                    n.sd    = n.sh[WORD_W-1];
                    n.sh    = n.sh << 1;
                    n.wbits = n.wbits - WB_W'(1);
                end
                n.left = n.left - CNT_W'(1);
            end else if (q.started && q.lead != '0) begin
                n.lead = q.lead - DLY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign sdata    = q.sd;
    assign fsync    = q.fs;
    assign underrun = q.ur;
endmodule

// File: rtl/dpf_tx.sv
`timescale 1ns/1ps
module dpf_tx
    import dpf_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dual,
    input  logic [LEN_W-1:0]  cfg_len1,
    input  logic [WLC_W-1:0]  cfg_wlen1,
    input  logic [LEN_W-1:0]  cfg_len2,
    input  logic [WLC_W-1:0]  cfg_wlen2,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic              sdata_o,
    output logic              underrun_o
);
    frame_cfg_t        cfg_w;
    logic              tick;
    logic              take;
    logic              have;
    logic [WORD_W-1:0] word;

    assign cfg_w = '{dual: cfg_dual, len1: cfg_len1, wc1: cfg_wlen1,
                     len2: cfg_len2, wc2: cfg_wlen2, dly: cfg_delay};

    dpf_bitclk #(.HALF_CYC(HALF_CYC)) u_bitclk (
        .clk  (clk),
        .rst  (rst),
        .bclk (bclk_o),
        .tick (tick)
    );

    dpf_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .take     (take),
        .have     (have),
        .word     (word)
    );

    dpf_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cfg_in   (cfg_w),
        .have     (have),
        .word     (word),
        .take     (take),
        .sdata    (sdata_o),
        .fsync    (fsync_o),
        .underrun (underrun_o)
    );
endmodule

// File: rtl/dpf_tx_chk.sv
`timescale 1ns/1ps
module dpf_tx_chk #(
    parameter int HALF_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic bclk_o,
    input logic fsync_o,
    input logic sdata_o,
    input logic underrun_o,
    input logic in_valid,
    input logic in_ready
);
    localparam int RW = $clog2(HALF_CYC + 2) + 1;

    logic          last_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            run_q  <= '0;
        end else begin
            last_q <= bclk_o;
            run_q  <= (bclk_o == last_q) ? run_q + RW'(1) : RW'(1);
        end
    end

    AST_BCLK_HALF: assert property (@(posedge clk) disable iff (rst)
        (bclk_o != last_q) |-> (run_q == RW'(HALF_CYC)));  // R1

    AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        !$rose(bclk_o) |-> ($stable(sdata_o) && $stable(fsync_o)));  // R1

    AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        ($rose(bclk_o) && $past(fsync_o)) |-> !fsync_o);  // R3

    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> !underrun_o);  // R7

    AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);  // R8
endmodule

bind dpf_tx dpf_tx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bclk_o     (bclk_o),
    .fsync_o    (fsync_o),
    .sdata_o    (sdata_o),
    .underrun_o (underrun_o),
    .in_valid   (in_valid),
    .in_ready   (in_ready)
);

// File: tb/dpf_tx_test.sv
`timescale 1ns/1ps
module dpf_tx_test;

    typedef struct {
        bit       dual;
        int       len1;
        bit [2:0] wc1;
        int       len2;
        bit [2:0] wc2;
        bit [1:0] dly;
    } tcfg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dual = 1'b0;
    logic [6:0]  cfg_len1 = '0;
    logic [2:0]  cfg_wlen1 = '0;
    logic [6:0]  cfg_len2 = '0;
    logic [2:0]  cfg_wlen2 = '0;
    logic [1:0]  cfg_delay = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, bclk_o, fsync_o, sdata_o, underrun_o;

    int checks = 0;
    int errors = 0;
    int tick_n = 0;
    int ur_cnt = 0;

    logic [1:0]  exp_q[$];
    logic [31:0] word_q[$];
    int          starts[$];

    always #5 clk = ~clk;

    dpf_tx #(.HALF_CYC(2)) uut (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_len1(cfg_len1),
        .cfg_wlen1(cfg_wlen1), .cfg_len2(cfg_len2), .cfg_wlen2(cfg_wlen2),
        .cfg_delay(cfg_delay), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .bclk_o(bclk_o), .fsync_o(fsync_o),
        .sdata_o(sdata_o), .underrun_o(underrun_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int wlen(bit [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic int dval(bit [1:0] c);
        return (c == 2'd0) ? 0 : (c == 2'd1) ? 1 : 2;
    endfunction

    task automatic apply(tcfg_t c);
        cfg_dual  = c.dual;
        cfg_len1  = 7'(c.len1);
        cfg_wlen1 = c.wc1;
        cfg_len2  = 7'(c.len2);
        cfg_wlen2 = c.wc2;
        cfg_delay = c.dly;
    endtask

    // Builds the word list and the expected (sync, data) pair per bit.
    task automatic build(tcfg_t a, tcfg_t b, int na, int nb, output int extra_words);
        bit   bits[$];
        int   k = 0;
        int   d = dval(a.dly);
        int   nf = na + nb + 1;
        bits.delete(); starts.delete(); word_q.delete(); exp_q.delete();
        extra_words = 0;
        for (int f = 0; f < nf; f++) begin
            tcfg_t c = (f < na) ? a : b;
            int    nph = c.dual ? 2 : 1;
            if (nb == 0 && f == nf - 1) c = a;
            starts.push_back(bits.size());
            for (int ph = 0; ph < nph; ph++) begin
                int cnt = (ph == 0 ? c.len1 : c.len2) + 1;
                int wl  = wlen(ph == 0 ? c.wc1 : c.wc2);
                for (int w = 0; w < cnt; w++) begin
                    logic [31:0] v = (32'h9E3779B9 * 32'(k + 1)) ^ 32'h5A0F_C3A5;
                    k++;
                    if (f == nf - 1) begin
                        extra_words++;
                        for (int i = 0; i < wl; i++) bits.push_back(1'b0);
                    end else begin
                        word_q.push_back(v);
                        for (int i = wl - 1; i >= 0; i--) bits.push_back(v[i]);
                    end
                end
            end
        end
        starts.push_back(bits.size());
        for (int p = 0; p < d + bits.size(); p++) begin
            bit fs = 1'b0;
            foreach (starts[i]) if (starts[i] == p) fs = 1'b1;
            exp_q.push_back({fs, (p < d) ? 1'b0 : bits[p - d]});
        end
    endtask

    task automatic run_case(string tag, tcfg_t a, tcfg_t b, int na, int nb);
        int extra;
        int sw_at;
        build(a, b, na, nb, extra);
        sw_at = starts[na - 1] + 1;
        apply(a);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(bclk_o == 0 && fsync_o == 0 && sdata_o == 0 && underrun_o == 0,
            "R2", "outputs in reset", {bclk_o, fsync_o, sdata_o, underrun_o}, 0);
        chk(in_ready == 1, "R2", "in_ready in reset", in_ready, 1);
        rst = 1'b0;
        tick_n = 0;
        ur_cnt = 0;
        fork
            begin : driver
                for (int i = 0; i < word_q.size(); i++) begin
                    while (!in_ready) @(negedge clk);
                    in_valid = 1'b1;
                    in_data  = word_q[i];
                    @(negedge clk);
                    if (i == 0) chk(in_ready == 0, "R8", "ready after accept", in_ready, 0);
                    in_valid = 1'b0;
                end
            end
            begin : cfg_switch
                if (nb > 0) begin
                    wait (tick_n == sw_at);
                    apply(b);
                end
            end
            begin : monitor
                logic prev = 1'b0;
                while (exp_q.size() > 0) begin
                    @(negedge clk);
                    if (underrun_o) ur_cnt++;
                    if (bclk_o && !prev) begin
                        logic [1:0] e = exp_q.pop_front();
                        chk(fsync_o == e[1], "R3 R6", $sformatf("%s sync bit %0d", tag, tick_n),
                            fsync_o, e[1]);
                        chk(sdata_o == e[0], tag, $sformatf("data bit %0d", tick_n),
                            sdata_o, e[0]);
                        tick_n++;
                    end
                    prev = bclk_o;
                end
            end
        join
        chk(ur_cnt == extra, "R7", "underrun pulses", ur_cnt, extra);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tick_n, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tcfg_t ac, sp, d2a, d2b, tiny;
        int    hi, lo;
        ac   = '{dual: 1, len1: 0, wc1: 3'b010, len2: 11, wc2: 3'b011, dly: 2'b01};
        sp   = '{dual: 0, len1: 3, wc1: 3'b000, len2: 5, wc2: 3'b101, dly: 2'b00};
        d2a  = '{dual: 1, len1: 1, wc1: 3'b101, len2: 2, wc2: 3'b001, dly: 2'b10};
        d2b  = '{dual: 1, len1: 0, wc1: 3'b100, len2: 1, wc2: 3'b000, dly: 2'b10};
        tiny = '{dual: 0, len1: 0, wc1: 3'b001, len2: 9, wc2: 3'b100, dly: 2'b01};

        // R1: bit clock period
        apply(ac);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        while (!bclk_o) @(negedge clk);
        hi = 0;
        while (bclk_o) begin hi++; @(negedge clk); end
        lo = 0;
        while (!bclk_o) begin lo++; @(negedge clk); end
        chk(hi == 2, "R1", "bclk high cycles", hi, 2);
        chk(lo == 2, "R1", "bclk low cycles", lo, 2);

        run_case("R4 R6", ac, ac, 2, 0);
        run_case("R5", sp, sp, 3, 0);
        run_case("R9", d2a, d2b, 2, 2);
        run_case("R5 R6", tiny, tiny, 4, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule